// File: doc/BRIEF.md
# Paged Memory Address Mapper

This block translates the addresses of a 16-bit CPU bus into addresses for a large external RAM. The 64 KiB logical space is cut into sixteen 4 KiB windows. Each window has a mapping register that names a physical page, so any window can point at any 4 KiB page of a memory of up to 32 MiB. The upper four address bits pick the window. The lower twelve bits pass through unchanged as the offset within the page.

The CPU reaches the sixteen mapping registers through a small register window at word addresses 0x4000 to 0x401E. That window answers only while a card-select control input is high. A second control input chooses the mode. In transparent mode, window n goes to physical page n. In mapped mode, the register contents are used. Each register word holds a page byte in its upper half and a bank byte in its lower half. Only the page byte can be read back. The bank bits go into write-only latches and affect only the physical address. The bus decode, the register file, the readback mux and the translation are inside the block. The RAM and the CPU are outside it.

Top module: `pgmap_top`

## Requirements
- R1: Synchronous reset clears every page and bank field to zero. After reset, a mapped access in any window gives a physical page and bank of zero. A read of any register returns 0x0000.
- R2: `reg_hit` is high exactly when `ctl_reg_en` is 1, `bus_addr` is even, and `bus_addr` lies in 0x4000..0x401E. Register n sits at 0x4000 + 2·n.
- R3: While `ctl_reg_en` is 0, a write strobe at a register address changes no register. A later enabled readback, or a later mapped translation, shows the old contents.
- R4: An enabled read (`bus_re`=1, `bus_we`=0) of register n returns `{page, page}`: the page byte in bits 15:8 and again in bits 7:0. The bank byte never appears in the read data.
- R5: When `ctl_map_en` is 0, `phys_addr` equals `{bank=0, page=bus_addr[15:12] zero-extended to 8 bits, bus_addr[11:0]}`.
- R6: When `ctl_map_en` is 1, `phys_addr` equals `{bank[4:0], page[7:0], bus_addr[11:0]}` of the register chosen by `bus_addr[15:12]`. Bits 24:20 are the bank, bits 19:12 are the page, and bits 11:0 are the offset.
- R7: A write stores `bus_wdata[15:8]` as the page and only the low BANK_BITS bits of `bus_wdata[7:0]` as the bank. Bank bits above that are dropped.
- R8: A register write takes effect at the clock edge that samples it. The translation from `bus_addr` to `phys_addr` is combinational, so it reflects the new value in the next cycle.
- R9: Odd addresses and addresses outside 0x4000..0x401E never hit and never write a register. `bus_rdata` is 0x0000 whenever no enabled read hits.
- R10: When register n holds page n with bank 0, for every window n from 2 to 15, the mapped physical address equals the transparent physical address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_reg_en | input | 1 | Card select; opens the register window |
| ctl_map_en | input | 1 | 1 = mapped mode, 0 = transparent mode |
| bus_addr | input | 16 | CPU logical word address |
| bus_wdata | input | 16 | CPU write data |
| bus_re | input | 1 | Read strobe |
| bus_we | input | 1 | Write strobe (wins over read) |
| reg_hit | output | 1 | Register window selected by this address |
| bus_rdata | output | 16 | Register readback, `{page, page}` |
| phys_addr | output | 25 | Extended physical address `{bank, page, offset}` |

## Verification
The bank field is the hardest state to observe. It cannot be read back, so it shows only in bits 24:20 of `phys_addr` during a mapped access to its window. For the same reason, a write blocked by a low card select can be seen only by a later enabled readback or a mapped translation. The stimulus therefore fills registers with data whose bank byte is different from the page byte and sets bits above the implemented bank width. It then attempts writes with the card deselected and at odd or out-of-range addresses. It then sweeps every window in mapped mode, so a reference model that tracks page and bank separately compares both fields on every clock.

// File: rtl/pgmap_pkg.sv
package pgmap_pkg;

    localparam int DEF_WIN_BITS  = 4;
    localparam int DEF_OFF_BITS  = 12;
    localparam int DEF_PAGE_BITS = 8;
    localparam int DEF_BANK_BITS = 5;
    localparam logic [15:0] DEF_REG_BASE = 16'h4000;

    // Kind of CPU access seen on the strobes
    typedef enum logic [1:0] {
        ACC_IDLE  = 2'b00,
        ACC_READ  = 2'b01,
        ACC_WRITE = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_kind_e;

    function automatic acc_kind_e classify(input logic re, input logic we);
        return acc_kind_e'({we, re});
    endfunction

    // Width of stored bank field; at least one bit so vectors stay legal
    function automatic int bank_slots(input int bank_bits);
        return (bank_bits > 0) ? bank_bits : 1;
    endfunction

endpackage

// File: rtl/pgmap_decode.sv
module pgmap_decode
    import pgmap_pkg::*;
#(
    parameter int WIN_BITS = DEF_WIN_BITS,
    parameter int ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_BASE = DEF_REG_BASE
) (
    input  logic                ctl_reg_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                re,
    input  logic                we,
    output logic                hit,
    output logic [WIN_BITS-1:0] idx,
    output logic                wr_stb,
    output logic                rd_stb
);
    // register block spans 2 * 2**WIN_BITS bytes
    localparam int SPAN_BITS = WIN_BITS + 1;

    acc_kind_e kind;
    logic      base_match;
    logic      even_addr;

    assign base_match = (addr[ADDR_W-1:SPAN_BITS] == REG_BASE[ADDR_W-1:SPAN_BITS]);
    assign even_addr  = ~addr[0];
    assign kind       = classify(re, we);

    always_comb begin
        hit    = ctl_reg_en & base_match & even_addr;
        idx    = addr[SPAN_BITS-1:1];
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        unique case (kind)
            ACC_WRITE, ACC_BOTH: wr_stb = hit;
            ACC_READ:            rd_stb = hit;
            default: ;
        endcase
    end

endmodule

// File: rtl/pgmap_regfile.sv
module pgmap_regfile
    import pgmap_pkg::*;
#(
    parameter int NWIN      = 16,
    parameter int IDX_W     = DEF_WIN_BITS,
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int BANK_BITS = DEF_BANK_BITS,
    parameter int BANK_W    = bank_slots(BANK_BITS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_stb,
    input  logic [IDX_W-1:0]          idx,
    input  logic [PAGE_BITS-1:0]      wr_page,
    input  logic [BANK_W-1:0]         wr_bank,
    output logic [NWIN*PAGE_BITS-1:0] page_vec,
    output logic [NWIN*BANK_W-1:0]    bank_vec
);

    for (genvar g = 0; g < NWIN; g++) begin : g_reg
        logic sel;
        logic [PAGE_BITS-1:0] page_q;

        assign sel = wr_stb && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                page_q <= '0;
            end else if (sel) begin
                page_q <= wr_page;
            end
        end
        assign page_vec[g*PAGE_BITS +: PAGE_BITS] = page_q;

        if (BANK_BITS > 0) begin : g_bank
            // write-only latch: feeds translation only
            logic [BANK_W-1:0] bank_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank_q <= '0;
                end else if (sel) begin
                    bank_q <= wr_bank;
                end
            end
            assign bank_vec[g*BANK_W +: BANK_W] = bank_q;
        end else begin : g_nobank
            assign bank_vec[g*BANK_W +: BANK_W] = '0;
        end
    end

endmodule

// File: rtl/pgmap_readback.sv
module pgmap_readback #(
    parameter int NWIN      = 16,
    parameter int IDX_W     = 4,
    parameter int PAGE_BITS = 8
) (
    input  logic                      rd_stb,
    input  logic [IDX_W-1:0]          idx,
    input  logic [NWIN*PAGE_BITS-1:0] page_vec,
    output logic [2*PAGE_BITS-1:0]    rdata
);
    logic [PAGE_BITS-1:0] sel_page;

    assign sel_page = page_vec[idx*PAGE_BITS +: PAGE_BITS];
    // page byte mirrored into both halves; bank is never returned
    assign rdata = rd_stb ? {2{sel_page}} : '0;

endmodule

// File: rtl/pgmap_xlate.sv
module pgmap_xlate
    import pgmap_pkg::*;
#(
    parameter int NWIN      = 16,
    parameter int WIN_BITS  = DEF_WIN_BITS,
    parameter int OFF_BITS  = DEF_OFF_BITS,
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int BANK_BITS = DEF_BANK_BITS,
    parameter int BANK_W    = bank_slots(BANK_BITS),
    parameter int ADDR_W    = WIN_BITS + OFF_BITS,
    parameter int PA_W      = BANK_BITS + PAGE_BITS + OFF_BITS
) (
    input  logic                      map_en,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [NWIN*PAGE_BITS-1:0] page_vec,
    input  logic [NWIN*BANK_W-1:0]    bank_vec,
    output logic [PA_W-1:0]           phys
);
    logic [WIN_BITS-1:0]  win;
    logic [OFF_BITS-1:0]  off;
    logic [PAGE_BITS-1:0] pg_sel;
    logic [BANK_W-1:0]    bk_sel;

    assign win = addr[ADDR_W-1 -: WIN_BITS];
    assign off = addr[OFF_BITS-1:0];

    always_comb begin
        if (map_en) begin
            pg_sel = page_vec[win*PAGE_BITS +: PAGE_BITS];
            bk_sel = bank_vec[win*BANK_W +: BANK_W];
        end else begin
            pg_sel = PAGE_BITS'(win);
            bk_sel = '0;
        end
    end

    if (BANK_BITS > 0) begin : g_with_bank
        assign phys = {bk_sel[BANK_BITS-1:0], pg_sel, off};
    end else begin : g_page_only
        logic unused_bank;
        assign unused_bank = ^bk_sel;
        assign phys = {pg_sel, off};
    end

endmodule

// File: rtl/pgmap_top.sv
module pgmap_top
    import pgmap_pkg::*;
#(
    parameter int WIN_BITS  = DEF_WIN_BITS,
    parameter int OFF_BITS  = DEF_OFF_BITS,
    parameter int PAGE_BITS = DEF_PAGE_BITS,
    parameter int BANK_BITS = DEF_BANK_BITS,
    parameter logic [15:0] REG_BASE = DEF_REG_BASE,
    localparam int NWIN   = 1 << WIN_BITS,
    localparam int ADDR_W = WIN_BITS + OFF_BITS,
    localparam int DATA_W = 2 * PAGE_BITS,
    localparam int BANK_W = bank_slots(BANK_BITS),
    localparam int PA_W   = BANK_BITS + PAGE_BITS + OFF_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_reg_en,
    input  logic              ctl_map_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_re,
    input  logic              bus_we,
    output logic              reg_hit,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [PA_W-1:0]   phys_addr
);
    logic [WIN_BITS-1:0]       idx;
    logic                      wr_stb;
    logic                      rd_stb;
    logic [NWIN*PAGE_BITS-1:0] page_vec;
    logic [NWIN*BANK_W-1:0]    bank_vec;
    logic [PAGE_BITS-1:0]      wr_page;
    logic [BANK_W-1:0]         wr_bank;
    logic                      unused_wdata;

    // page byte is the upper half, bank byte the lower half
    assign wr_page      = bus_wdata[DATA_W-1 -: PAGE_BITS];
    assign wr_bank      = bus_wdata[BANK_W-1:0];
    assign unused_wdata = ^bus_wdata;

    pgmap_decode #(
        .WIN_BITS (WIN_BITS),
        .ADDR_W   (ADDR_W),
        .REG_BASE (REG_BASE)
    ) u_decode (
        .ctl_reg_en (ctl_reg_en),
        .addr       (bus_addr),
        .re         (bus_re),
        .we         (bus_we),
        .hit        (reg_hit),
        .idx        (idx),
        .wr_stb     (wr_stb),
        .rd_stb     (rd_stb)
    );

    pgmap_regfile #(
        .NWIN      (NWIN),
        .IDX_W     (WIN_BITS),
        .PAGE_BITS (PAGE_BITS),
        .BANK_BITS (BANK_BITS),
        .BANK_W    (BANK_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_stb   (wr_stb),
        .idx      (idx),
        .wr_page  (wr_page),
        .wr_bank  (wr_bank),
        .page_vec (page_vec),
        .bank_vec (bank_vec)
    );

    pgmap_readback #(
        .NWIN      (NWIN),
        .IDX_W     (WIN_BITS),
        .PAGE_BITS (PAGE_BITS)
    ) u_rdback (
        .rd_stb   (rd_stb),
        .idx      (idx),
        .page_vec (page_vec),
        .rdata    (bus_rdata)
    );

    pgmap_xlate #(
        .NWIN      (NWIN),
        .WIN_BITS  (WIN_BITS),
        .OFF_BITS  (OFF_BITS),
        .PAGE_BITS (PAGE_BITS),
        .BANK_BITS (BANK_BITS),
        .BANK_W    (BANK_W),
        .ADDR_W    (ADDR_W),
        .PA_W      (PA_W)
    ) u_xlate (
        .map_en   (ctl_map_en),
        .addr     (bus_addr),
        .page_vec (page_vec),
        .bank_vec (bank_vec),
        .phys     (phys_addr)
    );

endmodule

// File: rtl/pgmap_checker.sv
module pgmap_checker #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int OFF_BITS = 12,
    parameter int PA_W     = 25,
    parameter int WIN_BITS = 4,
    parameter logic [15:0] REG_BASE = 16'h4000
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_reg_en,
    input logic              ctl_map_en,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_re,
    input logic              bus_we,
    input logic              reg_hit,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [PA_W-1:0]   phys_addr
);
    localparam int HB = DATA_W / 2;
    localparam logic [ADDR_W-1:0] REG_LAST = REG_BASE + ADDR_W'((1 << (WIN_BITS + 1)) - 2);

    // R1: first cycle out of reset, mapped page/bank are zero
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ctl_map_en) |-> (phys_addr[PA_W-1:OFF_BITS] == '0));

    // R2: a hit needs card select, an even address and the register range
    assert_hit_gate_R2: assert property (@(posedge clk) disable iff (rst)
        reg_hit |-> (ctl_reg_en && !bus_addr[0] &&
                     bus_addr >= REG_BASE && bus_addr <= REG_LAST));

    // R3: deselected window never answers
    assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        !ctl_reg_en |-> (!reg_hit && bus_rdata == '0));

    // R4: read data mirrors the page byte
    assert_mirror_R4: assert property (@(posedge clk) disable iff (rst)
        (reg_hit && bus_re && !bus_we) |-> (bus_rdata[DATA_W-1:HB] == bus_rdata[HB-1:0]));

    // R5: transparent mode is identity on window number
    assert_transparent_R5: assert property (@(posedge clk) disable iff (rst)
        !ctl_map_en |-> (phys_addr == PA_W'(bus_addr)));

    // R6: offset always passes through
    assert_offset_R6: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_BITS-1:0] == bus_addr[OFF_BITS-1:0]);

    // R8: without a write, same address and mode give the same translation
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_hit && bus_we) && $stable(bus_addr) && $stable(ctl_map_en))
        |-> $stable(phys_addr));

    // R9: no enabled read hit, no read data
    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
        !(reg_hit && bus_re && !bus_we) |-> (bus_rdata == '0));

endmodule

bind pgmap_top pgmap_checker #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .OFF_BITS (OFF_BITS),
    .PA_W     (PA_W),
    .WIN_BITS (WIN_BITS),
    .REG_BASE (REG_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctl_reg_en (ctl_reg_en),
    .ctl_map_en (ctl_map_en),
    .bus_addr   (bus_addr),
    .bus_re     (bus_re),
    .bus_we     (bus_we),
    .reg_hit    (reg_hit),
    .bus_rdata  (bus_rdata),
    .phys_addr  (phys_addr)
);

// File: tb/pgmap_top_tb.sv
`timescale 1ns/1ps
module pgmap_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_reg_en = 1'b0;
    logic        ctl_map_en = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_re = 1'b0;
    logic        bus_we = 1'b0;
    logic        reg_hit;
    logic [15:0] bus_rdata;
    logic [24:0] phys_addr;

    int tests = 0;
    int fails = 0;
    string phase = "R1";

    // reference model state
    int m_page [16];
    int m_bank [16];

    always #2 clk = ~clk;   // 250 MHz

    pgmap_top u_dut (
        .clk(clk), .rst(rst), .ctl_reg_en(ctl_reg_en), .ctl_map_en(ctl_map_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_we(bus_we),
        .reg_hit(reg_hit), .bus_rdata(bus_rdata), .phys_addr(phys_addr)
    );

    function automatic bit exp_hit();
        return ctl_reg_en && bus_addr >= 16'h4000 && bus_addr <= 16'h401E && !bus_addr[0];
    endfunction

    function automatic int reg_of(input logic [15:0] a);
        return int'((a - 16'h4000) >> 1);
    endfunction

    function automatic logic [15:0] exp_rdata();
        logic [7:0] p;
        if (exp_hit() && bus_re && !bus_we) begin
            p = 8'(m_page[reg_of(bus_addr)]);
            return {p, p};
        end
        return 16'h0000;
    endfunction

    function automatic logic [24:0] exp_phys();
        int w = int'(bus_addr >> 12);
        if (ctl_map_en)
            return {5'(m_bank[w]), 8'(m_page[w]), bus_addr[11:0]};
        return {5'd0, 8'(w), bus_addr[11:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (phase %s) addr=%h actual=%h expected=%h", req, phase, bus_addr, act, exp);
        end
    endtask

    // model update at the active edge
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) begin m_page[i] = 0; m_bank[i] = 0; end
        end else if (exp_hit() && bus_we) begin
            m_page[reg_of(bus_addr)] = int'(bus_wdata[15:8]);
            m_bank[reg_of(bus_addr)] = int'(bus_wdata[4:0]);   // R7: upper bank bits dropped
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check("R2", 32'(reg_hit), 32'(exp_hit()));
            check((exp_hit() && bus_re) ? "R4" : "R9", 32'(bus_rdata), 32'(exp_rdata()));
            check(ctl_map_en ? "R6" : "R5", 32'(phys_addr), 32'(exp_phys()));
        end
    end

    task automatic drive(input logic re_en, input logic map, input logic [15:0] a,
                         input logic [15:0] d, input logic re, input logic we);
        @(posedge clk);
        #1;
        ctl_reg_en = re_en; ctl_map_en = map; bus_addr = a;
        bus_wdata = d; bus_re = re; bus_we = we;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [24:0] p_map;
        logic [24:0] p_tr;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;

        // R1: after reset every mapped window is page 0, every register reads 0
        phase = "R1";
        for (int w = 0; w < 16; w++) drive(0, 1, 16'(w << 12) | 16'h0ABC, 0, 0, 0);
        for (int n = 0; n < 16; n++) drive(1, 0, 16'h4000 + 16'(2 * n), 0, 1, 0);

        // R5: transparent sweep
        phase = "R5";
        for (int w = 0; w < 16; w++) drive(0, 0, 16'(w << 12) | 16'(w * 97), 0, 0, 0);

        // R2, R7: fill registers, bank byte with extra high bits set
        phase = "R7";
        for (int n = 0; n < 16; n++)
            drive(1, 0, 16'h4000 + 16'(2 * n), {8'(8'hA0 + n), 8'(8'hE0 | (n + 3))}, 0, 1);
        // R4: readback shows page byte twice, never the bank
        phase = "R4";
        for (int n = 0; n < 16; n++) drive(1, 0, 16'h4000 + 16'(2 * n), 0, 1, 0);

        // R3: deselected write is ignored, then read back through enabled window
        phase = "R3";
        drive(0, 1, 16'h4004, 16'h5511, 0, 1);
        drive(1, 1, 16'h4004, 0, 1, 0);
        drive(1, 1, 16'h2123, 0, 0, 0);

        // R9: odd and out-of-range addresses do not write
        phase = "R9";
        drive(1, 0, 16'h4005, 16'h7777, 0, 1);
        drive(1, 0, 16'h4020, 16'h6666, 0, 1);
        drive(1, 0, 16'h3FFE, 16'h6666, 0, 1);
        drive(1, 0, 16'h4004, 0, 1, 0);
        drive(1, 0, 16'h401F, 0, 1, 0);

        // R6: mapped sweep shows page and bank
        phase = "R6";
        for (int w = 0; w < 16; w++) drive(0, 1, 16'(w << 12) | 16'h0FFF, 0, 0, 0);

        // R8: write then access same window on the next cycle
        phase = "R8";
        drive(1, 1, 16'h4006, 16'h3C09, 0, 1);
        drive(1, 1, 16'h3456, 0, 0, 0);

        // R10: identity initialisation of windows 2..15
        phase = "R10";
        for (int n = 2; n < 16; n++) drive(1, 0, 16'h4000 + 16'(2 * n), {8'(n), 8'h00}, 0, 1);
        for (int w = 2; w < 16; w++) begin
            drive(0, 1, 16'(w << 12) | 16'h0123, 0, 0, 0);
            @(negedge clk); p_map = phys_addr;
            drive(0, 0, 16'(w << 12) | 16'h0123, 0, 0, 0);
            @(negedge clk); p_tr = phys_addr;
            check("R10", 32'(p_map), 32'(p_tr));
        end

        // mixed traffic, model compared every clock
        phase = "mixed";
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a;
            logic we;
            a = ($urandom % 3 == 0) ? (16'h4000 + 16'($urandom % 34)) : 16'($urandom);
            we = ($urandom % 2) == 1;
            drive(($urandom % 4) != 0, ($urandom % 2) == 1, a, 16'($urandom), !we, we);
        end

        drive(0, 0, 0, 0, 0, 0);
        @(negedge clk);
        finish_run();
    end

endmodule